// File: doc/BRIEF.md
# Deadband PI Reactive Demand Controller

This block converts a filtered bus-voltage sample into a positive reactive-power demand word for a switched shunt-capacitor bank. All voltage quantities are signed fixed-point numbers in milli-percent, so 1000 counts are one percent. The block forms the error as the measured voltage minus the reference. It then passes the error through a dead zone, whose lower and upper limits arrive on ports as offsets from the reference. A proportional-integral law in ideal form acts on the dead-zone output. The law saturates at a symmetric limit and uses clamping anti-windup. The result is negated, so a sagging bus asks for positive demand.

The integrator advances once per sample strobe, and the sample period is 2^-SAMPLE_SHIFT seconds. When the voltage returns inside the window, the dead-zone output is zero and the demand settles to the integral term and stays there. The downstream branch selector therefore sees a steady value. Strobes are ignored for the first two seconds after reset and while the external inhibit input is high. The upper limit is a live port, so a neighbouring block can widen the window at run time.

Top module: `dbpi_demand_ctrl`

## Requirements
- R1: While rst_i is high, on each clock edge the integral state and demand_o are cleared to 0 and the startup count restarts.
- R2: After reset, the first STARTUP_N = 2 << SAMPLE_SHIFT strobes (128 by default) are ignored, and demand_o stays 0.
- R3: A strobe taken while inhibit_i is high changes neither the integral state nor demand_o.
- R4: In a clock cycle without strobe_i, demand_o keeps its value.
- R5: The error is e = volt_i - vref_i. The dead-zone output dz is 0 for band_lo_i <= e <= band_hi_i, e - band_hi_i for e > band_hi_i, and e - band_lo_i for e < band_lo_i.
- R6: On an accepted strobe, the new integral is I' = sat(I + floor(KP*KI*dz / 2^SAMPLE_SHIFT)), and demand_o becomes -sat(KP*dz + I') one clock later. Here sat limits to ±LIMIT (700000 by default), KP=100 and KI=300.
- R7: Clamping anti-windup: when KP*dz + I already lies beyond +LIMIT with dz > 0, or below -LIMIT with dz < 0, the integral is held at I.
- R8: While e stays inside the window, each accepted strobe sets demand_o to -I, and that value does not change on later strobes.
- R9: |demand_o| never exceeds LIMIT.
- R10: A voltage below the window produces a positive demand.
- R11: A change of band_hi_i takes effect at the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | One-cycle sample strobe |
| inhibit_i | input | 1 | Ignore strobes while high |
| volt_i | input | DW | Filtered bus voltage, milli-percent, signed |
| vref_i | input | DW | Reference voltage, milli-percent, signed |
| band_hi_i | input | DW | Upper window limit relative to reference, signed |
| band_lo_i | input | DW | Lower window limit relative to reference, signed |
| demand_o | output | DW | Registered reactive demand, signed |

## Verification
The integral term is the only hidden state. It surfaces one clock after any accepted strobe taken while the error is inside the window, where demand_o equals its negation. A wrong integral step, a missing anti-windup hold or a failed startup count therefore shows on the very next in-window strobe, or as a wrong demand on the first strobe after the startup interval. The bench sweeps the error across both window edges, one count at a time, and compares every strobe against an arithmetic model. It also saturates the loop hard and then returns the voltage into the window, to expose wound-up state.

// File: rtl/dbpi_pkg.sv
package dbpi_pkg;
  localparam int AW = 48;

  function automatic logic signed [AW-1:0] sat_sym(input logic signed [AW-1:0] x,
                                                   input logic signed [AW-1:0] lim);
    if (x > lim)
      sat_sym = lim;
    else if (x < -lim)
      sat_sym = -lim;
    else
      sat_sym = x;
  endfunction
endpackage

// File: rtl/dbpi_deadzone.sv
module dbpi_deadzone #(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] volt_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] hi_i,
  input  logic signed [DW-1:0] lo_i,
  output logic signed [DW+1:0] dz_o
);
  localparam int EW = DW + 1;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] hi_x;
  logic signed [EW-1:0] lo_x;
  logic signed [EW:0]   over;
  logic signed [EW:0]   under;

  always_comb begin
    err   = $signed({volt_i[DW-1], volt_i}) - $signed({vref_i[DW-1], vref_i});
    hi_x  = $signed({hi_i[DW-1], hi_i});
    lo_x  = $signed({lo_i[DW-1], lo_i});
    over  = $signed({err[EW-1], err}) - $signed({hi_x[EW-1], hi_x});
    under = $signed({err[EW-1], err}) - $signed({lo_x[EW-1], lo_x});
    if (err > hi_x)
      dz_o = over;
    else if (err < lo_x)
      dz_o = under;
    else
      dz_o = '0;
  end
endmodule

// File: rtl/dbpi_startup.sv
module dbpi_startup #(
  parameter int COUNT = 128
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic ready_o
);
  localparam int CW = (COUNT < 1) ? 1 : $clog2(COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(COUNT);

  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i)
      cnt_q <= '0;
    else if (strobe_i && !ready_o)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbpi_integrator.sv
module dbpi_integrator
  import dbpi_pkg::*;
#(
  parameter int DZW   = 26,
  parameter int KP    = 100,
  parameter int KI    = 300,
  parameter int SHIFT = 6,
  parameter int LIMIT = 700000
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   upd_i,
  input  logic signed [DZW-1:0]  dz_i,
  output logic signed [AW-1:0]   prop_o,
  output logic signed [AW-1:0]   i_next_o
);
  localparam logic signed [AW-1:0] KP_W   = AW'(KP);
  localparam logic signed [AW-1:0] KPKI_W = AW'(KP * KI);
  localparam logic signed [AW-1:0] LIM_W  = AW'(LIMIT);

  logic signed [AW-1:0] i_q;
  logic signed [AW-1:0] dz_x;
  logic signed [AW-1:0] inc;
  logic signed [AW-1:0] raw_old;
  logic                 hold;

  always_comb begin
    dz_x     = {{(AW-DZW){dz_i[DZW-1]}}, dz_i};
    prop_o   = dz_x * KP_W;
    inc      = (dz_x * KPKI_W) >>> SHIFT;
    raw_old  = prop_o + i_q;
    hold     = ((raw_old > LIM_W) && (dz_x > 0)) ||
               ((raw_old < -LIM_W) && (dz_x < 0));
    i_next_o = hold ? i_q : sat_sym(i_q + inc, LIM_W);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      i_q <= '0;
    else if (upd_i)
      i_q <= i_next_o;
  end
endmodule

// File: rtl/dbpi_demand_ctrl.sv
module dbpi_demand_ctrl
  import dbpi_pkg::*;
#(
  parameter int DW           = 24,
  parameter int KP           = 100,
  parameter int KI           = 300,
  parameter int SAMPLE_SHIFT = 6,
  parameter int STARTUP_SEC  = 2,
  parameter int LIMIT        = 700000
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 strobe_i,
  input  logic                 inhibit_i,
  input  logic signed [DW-1:0] volt_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] band_hi_i,
  input  logic signed [DW-1:0] band_lo_i,
  output logic signed [DW-1:0] demand_o
);
  localparam int DZW       = DW + 2;
  localparam int STARTUP_N = STARTUP_SEC << SAMPLE_SHIFT;
  localparam logic signed [AW-1:0] LIM_W = AW'(LIMIT);

  logic signed [DZW-1:0] dz;
  logic                  ready;
  logic                  upd;
  logic signed [AW-1:0]  prop;
  logic signed [AW-1:0]  i_next;
  logic signed [AW-1:0]  u_sat;
  logic signed [AW-1:0]  neg;
  logic signed [DW-1:0]  demand_q;

  dbpi_deadzone #(.DW(DW)) u_dz (
    .volt_i (volt_i),
    .vref_i (vref_i),
    .hi_i   (band_hi_i),
    .lo_i   (band_lo_i),
    .dz_o   (dz)
  );

  dbpi_startup #(.COUNT(STARTUP_N)) u_start (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .ready_o  (ready)
  );

  assign upd = strobe_i && ready && !inhibit_i;

  dbpi_integrator #(
    .DZW   (DZW),
    .KP    (KP),
    .KI    (KI),
    .SHIFT (SAMPLE_SHIFT),
    .LIMIT (LIMIT)
  ) u_int (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .upd_i    (upd),
    .dz_i     (dz),
    .prop_o   (prop),
    .i_next_o (i_next)
  );

  always_comb begin
    u_sat = sat_sym(prop + i_next, LIM_W);
    neg   = -u_sat;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      demand_q <= '0;
    else if (upd)
      demand_q <= neg[DW-1:0];
  end

  assign demand_o = demand_q;
endmodule

// File: rtl/dbpi_demand_chk.sv
module dbpi_demand_chk #(
  parameter int DW    = 24,
  parameter int LIMIT = 700000
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 strobe_i,
  input logic                 inhibit_i,
  input logic signed [DW-1:0] demand_o
);
  localparam logic signed [DW-1:0] LIM_D = DW'(LIMIT);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) rst_i |=> (demand_o == '0)); // R1

  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && inhibit_i) |=> $stable(demand_o)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !strobe_i |=> $stable(demand_o)); // R4

  AST_DEMAND_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (demand_o <= LIM_D) && (demand_o >= -LIM_D)); // R9
endmodule

bind dbpi_demand_ctrl dbpi_demand_chk #(.DW(DW), .LIMIT(LIMIT)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .strobe_i  (strobe_i),
  .inhibit_i (inhibit_i),
  .demand_o  (demand_o)
);

// File: tb/sim_dbpi_demand_ctrl.sv
module sim_dbpi_demand_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 24;
  localparam int KP    = 100;
  localparam int KI    = 300;
  localparam int SHIFT = 6;
  localparam int LIMIT = 700000;
  localparam int STN   = 2 << SHIFT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic inhibit = 1'b0;
  logic signed [DW-1:0] volt = '0;
  logic signed [DW-1:0] vref = '0;
  logic signed [DW-1:0] bhi  = '0;
  logic signed [DW-1:0] blo  = '0;
  logic signed [DW-1:0] demand;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint m_i = 0;
  longint m_dem = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbpi_demand_ctrl #(.DW(DW), .KP(KP), .KI(KI), .SAMPLE_SHIFT(SHIFT),
                     .STARTUP_SEC(2), .LIMIT(LIMIT)) u0 (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .inhibit_i(inhibit),
    .volt_i(volt), .vref_i(vref), .band_hi_i(bhi), .band_lo_i(blo),
    .demand_o(demand)
  );

  function automatic longint sat(input longint x);
    if (x > LIMIT) return LIMIT;
    if (x < -LIMIT) return -LIMIT;
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_i = 0; m_dem = 0; m_cnt = 0;
  endtask

  // one strobe, model update, compare one clock after the capturing edge
  task automatic pulse(input longint v, input bit inh, input string req);
    longint e, dz, raw, inc;
    bit hold;
    @(negedge clk);
    volt = DW'(v);
    inhibit = inh;
    strobe = 1'b1;
    e = v - longint'(vref);
    if (e > bhi) dz = e - bhi;
    else if (e < blo) dz = e - blo;
    else dz = 0;
    if (m_cnt < STN) m_cnt++;
    else if (!inh) begin
      raw  = KP * dz + m_i;
      hold = (raw > LIMIT && dz > 0) || (raw < -LIMIT && dz < 0);
      inc  = (KP * KI * dz) >>> SHIFT;
      if (!hold) m_i = sat(m_i + inc);
      m_dem = -sat(KP * dz + m_i);
    end
    @(negedge clk);
    strobe = 1'b0;
    inhibit = 1'b0;
    check(req, longint'(demand), m_dem);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint held;
    vref = 100000; bhi = 2000; blo = -3000;
    do_reset();
    check("R1 reset clears demand", longint'(demand), 0);

    // R2: far below band, strobes during startup must have no effect
    for (int k = 0; k < STN; k++) pulse(90000, 1'b0, "R2 startup ignore");
    check("R2 demand zero after startup window", longint'(demand), 0);

    // R10: first accepted strobe, below band -> positive demand
    pulse(96990, 1'b0, "R6 first update");
    check("R10 positive demand below band", longint'(demand > 0), 1);

    // R4: idle cycles hold demand
    held = demand;
    repeat (5) @(negedge clk);
    check("R4 no strobe hold", longint'(demand), held);

    // R3: inhibited strobes
    pulse(50000, 1'b1, "R3 inhibit strobe");
    check("R3 inhibit keeps demand", longint'(demand), held);

    // R5/R6: sweep across both window edges one count at a time
    for (int d = -25; d <= 25; d++) pulse(100000 - 3000 + d, 1'b0, "R5 lower edge sweep");
    for (int d = -25; d <= 25; d++) pulse(100000 + 2000 + d, 1'b0, "R5 upper edge sweep");

    // R8: inside window demand equals -I and holds
    pulse(100000, 1'b0, "R8 in window");
    held = demand;
    check("R8 demand equals negated integral", longint'(demand), -m_i);
    pulse(101000, 1'b0, "R8 in window again");
    check("R8 held value", longint'(demand), held);

    // R11: widen upper limit at run time
    pulse(103000, 1'b0, "R11 above narrow band");
    bhi = 5000;
    pulse(103000, 1'b0, "R11 widened band");
    check("R11 widened band holds -I", longint'(demand), -m_i);
    bhi = 2000;

    // R7/R9: hard saturation from a clean state, then back into window
    do_reset();
    for (int k = 0; k < STN; k++) @(negedge clk);
    m_cnt = 0;
    for (int k = 0; k < STN; k++) pulse(100000, 1'b0, "R2 startup ignore");
    for (int k = 0; k < 40; k++) pulse(80000, 1'b0, "R9 saturated below");
    check("R9 demand at limit", longint'(demand), LIMIT);
    pulse(100000, 1'b0, "R7 return to window");
    check("R7 integral not wound up", longint'(demand), 0);
    for (int k = 0; k < 40; k++) pulse(120000, 1'b0, "R9 saturated above");
    check("R9 demand at negative limit", longint'(demand), -LIMIT);

    // R6: slow ramp that integrates toward the limit
    for (int k = 0; k < 120; k++) pulse(96000 - k * 7, 1'b0, "R6 ramp integrate");
    for (int k = 0; k < 60; k++) pulse(102500 + k * 11, 1'b0, "R6 ramp unwind");

    // R1: reset in the middle of operation
    do_reset();
    check("R1 reset mid run", longint'(demand), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule